// File: doc/BRIEF.md
# Console Register Interface with Subchannel Routing

This block sits between a processor's register bus and the console side of a machine. It holds a receive pair and a transmit pair of registers: a control/status word and a data word for each direction. A word written to the transmit data register carries a 4-bit destination field in bits 11:8. That field sends the low byte to the terminal character output, to the floppy data or floppy command strobe, to a lookup in a 128-byte communications region, or to a port of miscellaneous console actions. Lookups in the communications region return their byte through the receive data register, tagged with 0x300, so the driver reads answers from the same place it reads keystrokes.

The terminal serializer connects through a valid/ready character output and a valid-plus-break character input. The floppy sequencer sits outside the block. It sees one-cycle strobes carrying the byte. It answers with a "transmit complete" pulse, and it can load any 16-bit word into the receive data register. The block produces one interrupt request per direction.

The transmit side is a Moore state machine, `tx_state_e`, with these states:
- `TX_DONE`: idle, with transmit done set.
- `TX_TERM`: offering a character on the terminal output.
- `TX_FL_STROBE`: one cycle of floppy strobe.
- `TX_FL_WAIT`: waiting for the sequencer's completion pulse.
- `TX_WAIT`: a parameterised delay for the lookup, miscellaneous and unassigned selects.

Its transitions are:
- `TX_DONE` goes to `TX_TERM` on an accepted write with select 0.
- `TX_DONE` goes to `TX_FL_STROBE` on select 1 or 9.
- `TX_DONE` goes to `TX_WAIT` on any other select.
- `TX_TERM` goes to `TX_DONE` on the ready handshake.
- `TX_FL_STROBE` always goes to `TX_FL_WAIT`.
- `TX_FL_WAIT` goes to `TX_DONE` on the completion pulse.
- `TX_WAIT` goes to `TX_DONE` when its counter reaches zero.

Top module: `con_regif`

## Requirements
- R1: After reset the transmit status reads 0x0080 (done, bit 7), the receive status reads 0x0000, both data registers read 0, and both interrupt requests are low. Register addresses are: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data. In both status words, bit 7 is done and bit 6 is interrupt enable.
- R2: A transmit data write that is accepted is routed by bits 11:8 as follows: 0 goes to the terminal, 1 to the floppy data strobe, 9 to the floppy command strobe, 3 to a communications-region lookup, and F to the miscellaneous port. Any other value causes no port activity and only sets transmit done after the delay.
- R3: For select 0, `tch_valid` stays high with `tch_data` equal to the low byte until `tch_ready`. Transmit done is set on the cycle after the handshake. Transmit data writes made while done is clear are ignored.
- R4: An accepted transmit data write clears transmit done and the transmit interrupt request on the next cycle. Reading transmit data returns the last accepted word.
- R5: For select 1 or 9, the matching strobe is high for exactly one cycle with `fl_byte` equal to the low byte. Transmit done is set on the cycle after `fl_txdone`.
- R6: For select 3, bits 6:0 index the region. Receive data becomes 0x0300 ORed with the byte, receive done is set, and transmit done returns DONE_DELAY cycles after the write.
- R7: After reset the region is zero, with these exceptions: byte 0x64 holds 1, bytes 0x6A..0x6D hold VERSIONS bytes 0..3, and bytes 0x65 (warm start) and 0x66 (cold start) hold WARM_INIT and COLD_INIT.
- R8: For select F, code 3 clears bytes 0x65 and 0x66, and code 4 clears only byte 0x66. Code 1 pulses `sw_done` for one cycle and code 2 pulses `reboot` for one cycle.
- R9: A terminal character loads receive data with the byte and sets receive done. A break loads 0xA000 (error bit 15, framing bit 13). A character arriving while receive done is set also sets error bit 15 and overrun bit 14.
- R10: A receive data read returns the word, then clears receive done, drops the receive interrupt request and clears bits 15:8.
- R11: A status write with interrupt enable set while done is set raises that direction's request on the next cycle. A status write with interrupt enable clear drops it.
- R12: When done rises while interrupt enable is set, the request rises with it.
- R13: `fl_rx_valid` loads `fl_rx_word` into receive data and sets receive done. On the same cycle, a communications-region lookup wins over the floppy word, and the floppy word wins over a terminal character, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| tch_valid | output | 1 | Terminal character offered |
| tch_ready | input | 1 | Terminal serializer accepts |
| tch_data | output | 8 | Terminal character |
| rch_valid | input | 1 | Received terminal character strobe |
| rch_data | input | 8 | Received character |
| rch_break | input | 1 | Received event is a break |
| fl_data_valid | output | 1 | Floppy data strobe |
| fl_cmd_valid | output | 1 | Floppy command strobe |
| fl_byte | output | 8 | Byte for the floppy strobes |
| fl_txdone | input | 1 | Floppy sequencer took the byte |
| fl_rx_valid | input | 1 | Floppy word for receive data |
| fl_rx_word | input | 16 | Floppy receive word |
| sw_done | output | 1 | Software-done pulse |
| reboot | output | 1 | Reboot pulse |

## Verification
Several invariants are checked by the in-RTL assertions on every cycle:
- an interrupt request never stands without its done and enable bits;
- the terminal output holds steady while it is stalled;
- transmit writes made while busy leave the stored word unchanged;
- a receive data read clears done and the upper byte;
- the delay counter stays inside its window;
- cleared start bytes read zero.

Only the bench scenarios can show the rest: that each select value reaches the right port with the right byte, that lookups return the tagged values of the reset contents, that the miscellaneous codes clear the right bytes, and that receive-source priority, overrun and break words come out as specified.

// File: rtl/con_pkg.sv
package con_pkg;
    localparam int DW = 16;
    localparam int BW = 8;

    localparam logic [1:0] ADDR_RXCSR  = 2'd0;
    localparam logic [1:0] ADDR_RXDATA = 2'd1;
    localparam logic [1:0] ADDR_TXCSR  = 2'd2;
    localparam logic [1:0] ADDR_TXDATA = 2'd3;

    localparam int CSR_DONE_BIT = 7;
    localparam int CSR_IE_BIT   = 6;

    localparam logic [3:0] SEL_TERM  = 4'h0;
    localparam logic [3:0] SEL_FDATA = 4'h1;
    localparam logic [3:0] SEL_COMM  = 4'h3;
    localparam logic [3:0] SEL_FCMD  = 4'h9;
    localparam logic [3:0] SEL_MISC  = 4'hF;

    localparam logic [7:0] MISC_SWDONE    = 8'd1;
    localparam logic [7:0] MISC_REBOOT    = 8'd2;
    localparam logic [7:0] MISC_CLR_BOTH  = 8'd3;
    localparam logic [7:0] MISC_CLR_COLD  = 8'd4;

    localparam logic [15:0] RX_ERR_BIT   = 16'h8000;
    localparam logic [15:0] RX_OVR_BIT   = 16'h4000;
    localparam logic [15:0] RX_FRM_BIT   = 16'h2000;
    localparam logic [15:0] COMM_TAG     = 16'h0300;

    localparam int FLAG_IDX = 100;
    localparam int WARM_IDX = 101;
    localparam int COLD_IDX = 102;
    localparam int VER_IDX  = 106;
    localparam int VER_CNT  = 4;

    typedef enum logic [2:0] {
        TX_DONE,
        TX_TERM,
        TX_FL_STROBE,
        TX_FL_WAIT,
        TX_WAIT
    } tx_state_e;
endpackage

// File: rtl/con_commregion.sv
module con_commregion
    import con_pkg::*;
#(
    parameter int          DEPTH     = 128,
    parameter logic [31:0] VERSIONS  = 32'h0403_0201,
    parameter logic [7:0]  WARM_INIT = 8'h00,
    parameter logic [7:0]  COLD_INIT = 8'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [BW-1:0]            rd_byte,
    input  logic                     clr_warm,
    input  logic                     clr_cold
);
    function automatic logic [BW-1:0] reset_byte(input int idx);
        logic [BW-1:0] v;
        v = '0;
        if (idx == FLAG_IDX) v = 8'd1;
        else if (idx == WARM_IDX) v = WARM_INIT;
        else if (idx == COLD_IDX) v = COLD_INIT;
        else if (idx >= VER_IDX && idx < VER_IDX + VER_CNT)
            v = VERSIONS[8*(idx-VER_IDX) +: 8];
        return v;
    endfunction

    logic [BW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        if (i == WARM_IDX || i == COLD_IDX) begin : g_flag
            logic clr_this;
            assign clr_this = (i == COLD_IDX) ? clr_cold : clr_warm;
            always_ff @(posedge clk) begin
                if (!rst_n)        mem[i] <= reset_byte(i);
                else if (clr_this) mem[i] <= '0;
            end
            // R8: a clear request leaves the start byte at zero
            p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                clr_this |=> (mem[i] == '0));
        end else begin : g_const
            assign mem[i] = reset_byte(i);
        end
    end

    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/con_rxpath.sv
module con_rxpath
    import con_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_csr,
    input  logic          wr_ie,
    input  logic          rd_data,
    input  logic          comm_load,
    input  logic [DW-1:0] comm_word,
    input  logic          fl_load,
    input  logic [DW-1:0] fl_word,
    input  logic          ch_valid,
    input  logic [BW-1:0] ch_byte,
    input  logic          ch_break,
    output logic          done,
    output logic          ie,
    output logic          irq,
    output logic [DW-1:0] word
);
    logic          done_q, done_d, ie_q, ie_d, irq_q, irq_d;
    logic [DW-1:0] word_q, word_d, term_word;
    logic          load_any;

    assign load_any = comm_load || fl_load || ch_valid;

    always_comb begin
        if (ch_break) term_word = RX_ERR_BIT | RX_FRM_BIT;
        else if (done_q && !rd_data) term_word = RX_ERR_BIT | RX_OVR_BIT | {8'h00, ch_byte};
        else term_word = {8'h00, ch_byte};
    end

    always_comb begin
        done_d = done_q;
        ie_d   = wr_csr ? wr_ie : ie_q;
        irq_d  = irq_q;
        word_d = word_q;
        if (rd_data) begin
            done_d = 1'b0;
            irq_d  = 1'b0;
            word_d = {8'h00, word_q[7:0]};
        end
        if (load_any) begin
            done_d = 1'b1;
            if (ie_d) irq_d = 1'b1;
            if (comm_load)   word_d = comm_word;
            else if (fl_load) word_d = fl_word;
            else             word_d = term_word;
        end
        if (wr_csr) begin
            if (!wr_ie)      irq_d = 1'b0;
            else if (done_q) irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ie_q   <= 1'b0;
            irq_q  <= 1'b0;
            word_q <= '0;
        end else begin
            done_q <= done_d;
            ie_q   <= ie_d;
            irq_q  <= irq_d;
            word_q <= word_d;
        end
    end

    assign done = done_q;
    assign ie   = ie_q;
    assign irq  = irq_q;
    assign word = word_q;

    p_irq_needs_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (done_q && ie_q));
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !load_any) |=> (!done_q && !irq_q && word_q[15:8] == 8'h00));
    p_load_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_any |=> done_q);
endmodule

// File: rtl/con_txfsm.sv
module con_txfsm
    import con_pkg::*;
#(
    parameter int DONE_DELAY = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_csr,
    input  logic          wr_ie,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic          tch_ready,
    input  logic          fl_txdone,
    output logic          accept,
    output logic          done,
    output logic          ie,
    output logic          irq,
    output logic [DW-1:0] word,
    output logic          tch_valid,
    output logic          fd_valid,
    output logic          fc_valid,
    output logic [BW-1:0] out_byte
);
    localparam int CW = $clog2(DONE_DELAY + 1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] word_q;
    logic          ie_q, irq_q, irq_d, enter_done;
    logic [3:0]    new_sel, cur_sel;

    assign new_sel = wdata[11:8];
    assign cur_sel = word_q[11:8];
    assign accept  = wr_data && (state_q == TX_DONE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TX_DONE: begin
                if (wr_data) begin
                    if (new_sel == SEL_TERM) begin
                        state_d = TX_TERM;
                    end else if (new_sel == SEL_FDATA || new_sel == SEL_FCMD) begin
                        state_d = TX_FL_STROBE;
                    end else begin
                        state_d = TX_WAIT;
                        cnt_d   = CW'(DONE_DELAY - 1);
                    end
                end
            end
            TX_TERM:      if (tch_ready) state_d = TX_DONE;
            TX_FL_STROBE: state_d = TX_FL_WAIT;
            TX_FL_WAIT:   if (fl_txdone) state_d = TX_DONE;
            TX_WAIT: begin
                if (cnt_q == '0) state_d = TX_DONE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default:      state_d = TX_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_DONE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) word_q <= wdata;
        end
    end

    assign enter_done = (state_q != TX_DONE) && (state_d == TX_DONE);

    always_comb begin
        irq_d = irq_q;
        if (enter_done && ie_q) irq_d = 1'b1;
        if (accept)             irq_d = 1'b0;
        if (wr_csr) begin
            if (!wr_ie)                     irq_d = 1'b0;
            else if (state_q == TX_DONE)    irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (wr_csr) ie_q <= wr_ie;
            irq_q <= irq_d;
        end
    end

    always_comb begin
        done      = (state_q == TX_DONE);
        tch_valid = (state_q == TX_TERM);
        fd_valid  = (state_q == TX_FL_STROBE) && (cur_sel == SEL_FDATA);
        fc_valid  = (state_q == TX_FL_STROBE) && (cur_sel == SEL_FCMD);
        out_byte  = word_q[7:0];
        ie        = ie_q;
        irq       = irq_q;
        word      = word_q;
    end

    p_term_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tch_valid && !tch_ready) |=> (tch_valid && $stable(out_byte)));
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !done) |=> $stable(word_q));
    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && !irq_q));
    p_irq_needs_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (done && ie_q));
    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tch_valid, fd_valid, fc_valid}));
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid || fc_valid) |=> !(fd_valid || fc_valid));
    p_wait_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT) |-> (int'(cnt_q) < DONE_DELAY));
endmodule

// File: rtl/con_regif.sv
module con_regif
    import con_pkg::*;
#(
    parameter int          DONE_DELAY = 8,
    parameter int          COMM_DEPTH = 128,
    parameter logic [31:0] VERSIONS   = 32'h0403_0201,
    parameter logic [7:0]  WARM_INIT  = 8'h00,
    parameter logic [7:0]  COLD_INIT  = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        rx_irq,
    output logic        tx_irq,
    output logic        tch_valid,
    input  logic        tch_ready,
    output logic [7:0]  tch_data,
    input  logic        rch_valid,
    input  logic [7:0]  rch_data,
    input  logic        rch_break,
    output logic        fl_data_valid,
    output logic        fl_cmd_valid,
    output logic [7:0]  fl_byte,
    input  logic        fl_txdone,
    input  logic        fl_rx_valid,
    input  logic [15:0] fl_rx_word,
    output logic        sw_done,
    output logic        reboot
);
    localparam int IW = $clog2(COMM_DEPTH);

    logic          wr_rxcsr, rd_rxdata, wr_txcsr, wr_txdata;
    logic          tx_accept, tx_done, tx_ie, rx_done, rx_ie;
    logic [DW-1:0] tx_word, rx_word, comm_word;
    logic [BW-1:0] comm_byte, tx_byte, misc_code;
    logic [3:0]    sel;
    logic          comm_load, misc_hit, clr_warm, clr_cold;
    logic          sw_done_q, reboot_q;

    assign wr_rxcsr  = bus_wr && (bus_addr == ADDR_RXCSR);
    assign rd_rxdata = bus_rd && (bus_addr == ADDR_RXDATA);
    assign wr_txcsr  = bus_wr && (bus_addr == ADDR_TXCSR);
    assign wr_txdata = bus_wr && (bus_addr == ADDR_TXDATA);

    assign sel       = bus_wdata[11:8];
    assign misc_code = bus_wdata[7:0];
    assign comm_load = tx_accept && (sel == SEL_COMM);
    assign misc_hit  = tx_accept && (sel == SEL_MISC);
    assign clr_warm  = misc_hit && (misc_code == MISC_CLR_BOTH);
    assign clr_cold  = misc_hit && (misc_code == MISC_CLR_BOTH || misc_code == MISC_CLR_COLD);
    assign comm_word = COMM_TAG | {8'h00, comm_byte};

    con_txfsm #(.DONE_DELAY(DONE_DELAY)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_csr    (wr_txcsr),
        .wr_ie     (bus_wdata[CSR_IE_BIT]),
        .wr_data   (wr_txdata),
        .wdata     (bus_wdata),
        .tch_ready (tch_ready),
        .fl_txdone (fl_txdone),
        .accept    (tx_accept),
        .done      (tx_done),
        .ie        (tx_ie),
        .irq       (tx_irq),
        .word      (tx_word),
        .tch_valid (tch_valid),
        .fd_valid  (fl_data_valid),
        .fc_valid  (fl_cmd_valid),
        .out_byte  (tx_byte)
    );

    con_rxpath u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_csr    (wr_rxcsr),
        .wr_ie     (bus_wdata[CSR_IE_BIT]),
        .rd_data   (rd_rxdata),
        .comm_load (comm_load),
        .comm_word (comm_word),
        .fl_load   (fl_rx_valid),
        .fl_word   (fl_rx_word),
        .ch_valid  (rch_valid),
        .ch_byte   (rch_data),
        .ch_break  (rch_break),
        .done      (rx_done),
        .ie        (rx_ie),
        .irq       (rx_irq),
        .word      (rx_word)
    );

    con_commregion #(
        .DEPTH     (COMM_DEPTH),
        .VERSIONS  (VERSIONS),
        .WARM_INIT (WARM_INIT),
        .COLD_INIT (COLD_INIT)
    ) u_comm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (bus_wdata[IW-1:0]),
        .rd_byte  (comm_byte),
        .clr_warm (clr_warm),
        .clr_cold (clr_cold)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_done_q <= 1'b0;
            reboot_q  <= 1'b0;
        end else begin
            sw_done_q <= misc_hit && (misc_code == MISC_SWDONE);
            reboot_q  <= misc_hit && (misc_code == MISC_REBOOT);
        end
    end

    assign sw_done  = sw_done_q;
    assign reboot   = reboot_q;
    assign tch_data = tx_byte;
    assign fl_byte  = tx_byte;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_RXCSR:  begin
                bus_rdata[CSR_DONE_BIT] = rx_done;
                bus_rdata[CSR_IE_BIT]   = rx_ie;
            end
            ADDR_RXDATA: bus_rdata = rx_word;
            ADDR_TXCSR:  begin
                bus_rdata[CSR_DONE_BIT] = tx_done;
                bus_rdata[CSR_IE_BIT]   = tx_ie;
            end
            ADDR_TXDATA: bus_rdata = tx_word;
            default:     bus_rdata = '0;
        endcase
    end

    p_misc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_done || reboot) |=> !(sw_done || reboot));
    p_comm_sets_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        comm_load |=> (rx_done && rx_word[15:8] == 8'h03));
endmodule

// File: tb/con_regif_tb.sv
module con_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        rx_irq, tx_irq, tch_valid, fl_data_valid, fl_cmd_valid, sw_done, reboot;
    logic        tch_ready = 0, rch_valid = 0, rch_break = 0, fl_txdone = 0, fl_rx_valid = 0;
    logic [7:0]  tch_data, fl_byte, rch_data = 0;
    logic [15:0] fl_rx_word = 0;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [15:0] v;

    always #4 clk = ~clk;

    con_regif #(
        .DONE_DELAY (3),
        .VERSIONS   (32'h4433_2211),
        .WARM_INIT  (8'h5A),
        .COLD_INIT  (8'hA5)
    ) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic see(input int ev);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected port event actual=%h expected=none", ev);
        end else begin
            int e = exp_q.pop_front();
            if (e != ev) begin
                errors++;
                $display("FAIL R2 port event actual=%h expected=%h", ev, e);
            end
        end
    endtask

    // monitor: one item per output event
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (tch_valid && tch_ready) see(32'h100 | tch_data);
            if (fl_data_valid)          see(32'h200 | fl_byte);
            if (fl_cmd_valid)           see(32'h300 | fl_byte);
            if (sw_done)                see(32'h400);
            if (reboot)                 see(32'h500);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic comm_rd(input logic [6:0] idx, input logic [7:0] exp, input string req);
        logic [15:0] r;
        wr(2'd3, 16'h0300 | {9'h0, idx});
        rd(2'd1, r);
        chk(req, r, 16'h0300 | {8'h0, exp});
        cyc(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        // R1 reset state
        rd(2'd2, v); chk("R1 tx status", v, 16'h0080);
        rd(2'd0, v); chk("R1 rx status", v, 16'h0000);
        rd(2'd1, v); chk("R1 rx data", v, 16'h0000);
        rd(2'd3, v); chk("R1 tx data", v, 16'h0000);
        chk("R1 irqs", {rx_irq, tx_irq}, 2'b00);

        // R11 enable with done set raises request; rx has no done
        wr(2'd2, 16'h0040); chk("R11 tx irq on enable", tx_irq, 1'b1);
        wr(2'd0, 16'h0040); chk("R11 rx irq stays low", rx_irq, 1'b0);

        // R3/R4 terminal output
        tch_ready = 0;
        exp_q.push_back(32'h141);
        wr(2'd3, 16'h0041);
        chk("R4 tx irq cleared", tx_irq, 1'b0);
        rd(2'd2, v); chk("R4 tx done cleared", v, 16'h0040);
        wr(2'd3, 16'h0042);
        cyc(2);
        chk("R3 valid held", tch_valid, 1'b1);
        chk("R3 data held", tch_data, 8'h41);
        rd(2'd3, v); chk("R3 busy write ignored", v, 16'h0041);
        @(negedge clk); tch_ready = 1;
        @(negedge clk); tch_ready = 0;
        chk("R3 valid dropped", tch_valid, 1'b0);
        rd(2'd2, v); chk("R3 done after handshake", v, 16'h00C0);
        chk("R12 tx irq on done", tx_irq, 1'b1);

        // R5 floppy data and command
        exp_q.push_back(32'h2C7);
        wr(2'd3, 16'h01C7);
        cyc(2);
        rd(2'd2, v); chk("R5 waits for sequencer", v, 16'h0040);
        @(negedge clk); fl_txdone = 1;
        @(negedge clk); fl_txdone = 0;
        rd(2'd2, v); chk("R5 done after txdone", v, 16'h00C0);
        exp_q.push_back(32'h304);
        wr(2'd3, 16'h0904);
        cyc(1);
        @(negedge clk); fl_txdone = 1;
        @(negedge clk); fl_txdone = 0;

        // R6/R7 communications-region lookups
        wr(2'd3, 16'h036A);
        rd(2'd2, v); chk("R6 tx done clear during delay", v, 16'h0040);
        rd(2'd0, v); chk("R6 rx done set", v, 16'h00C0);
        chk("R6 rx irq", rx_irq, 1'b1);
        rd(2'd1, v); chk("R7 version byte 0", v, 16'h0311);
        chk("R10 rx irq dropped", rx_irq, 1'b0);
        rd(2'd0, v); chk("R10 rx done cleared", v, 16'h0040);
        rd(2'd1, v); chk("R10 upper byte cleared", v, 16'h0011);
        rd(2'd2, v); chk("R6 tx done after delay", v, 16'h00C0);
        cyc(2);
        comm_rd(7'h6D, 8'h44, "R7 version byte 3");
        wr(2'd3, 16'h03E4);
        rd(2'd1, v); chk("R6 index masked to 7 bits", v, 16'h0301);
        cyc(4);
        comm_rd(7'h00, 8'h00, "R7 zero byte");
        comm_rd(7'h65, 8'h5A, "R7 warm byte");
        comm_rd(7'h66, 8'hA5, "R7 cold byte");

        // R8 miscellaneous codes
        wr(2'd3, 16'h0F04); cyc(4);
        comm_rd(7'h66, 8'h00, "R8 code 4 clears cold");
        comm_rd(7'h65, 8'h5A, "R8 code 4 keeps warm");
        wr(2'd3, 16'h0F03); cyc(4);
        comm_rd(7'h65, 8'h00, "R8 code 3 clears warm");
        exp_q.push_back(32'h400);
        wr(2'd3, 16'h0F01); cyc(4);
        exp_q.push_back(32'h500);
        wr(2'd3, 16'h0F02); cyc(4);

        // R2 unassigned select: done only
        wr(2'd3, 16'h0500);
        rd(2'd2, v); chk("R2 unassigned select busy", v, 16'h0040);
        cyc(4);
        rd(2'd2, v); chk("R2 unassigned select done", v, 16'h00C0);

        // R9 terminal receive
        rd(2'd1, v);
        @(negedge clk); rch_valid = 1; rch_data = 8'h55;
        @(negedge clk); rch_valid = 0;
        chk("R9 rx irq on char", rx_irq, 1'b1);
        rd(2'd0, v); chk("R9 rx done", v, 16'h00C0);
        @(negedge clk); rch_valid = 1; rch_data = 8'h66;
        @(negedge clk); rch_valid = 0;
        rd(2'd1, v); chk("R9 overrun word", v, 16'hC066);
        rd(2'd1, v); chk("R10 errors cleared", v, 16'h0066);
        @(negedge clk); rch_valid = 1; rch_break = 1;
        @(negedge clk); rch_valid = 0; rch_break = 0;
        rd(2'd1, v); chk("R9 break word", v, 16'hA000);

        // R13 floppy receive word and priority
        @(negedge clk); fl_rx_valid = 1; fl_rx_word = 16'h0205;
        @(negedge clk); fl_rx_valid = 0;
        rd(2'd1, v); chk("R13 floppy word", v, 16'h0205);
        @(negedge clk); fl_rx_valid = 1; fl_rx_word = 16'h0123; rch_valid = 1; rch_data = 8'h77;
        @(negedge clk); fl_rx_valid = 0; rch_valid = 0;
        rd(2'd1, v); chk("R13 floppy beats terminal", v, 16'h0123);
        @(negedge clk); fl_rx_valid = 1; fl_rx_word = 16'h0999;
        bus_wr = 1; bus_addr = 2'd3; bus_wdata = 16'h0364;
        @(negedge clk); fl_rx_valid = 0; bus_wr = 0;
        rd(2'd1, v); chk("R13 lookup beats floppy", v, 16'h0301);
        cyc(4);

        // R11 disabling drops requests
        @(negedge clk); rch_valid = 1; rch_data = 8'h12;
        @(negedge clk); rch_valid = 0;
        chk("R11 rx irq before disable", rx_irq, 1'b1);
        wr(2'd0, 16'h0000); chk("R11 rx irq dropped", rx_irq, 1'b0);
        wr(2'd0, 16'h0040); chk("R11 rx irq re-raised", rx_irq, 1'b1);
        wr(2'd2, 16'h0000); chk("R11 tx irq dropped", tx_irq, 1'b0);

        cyc(4);
        chk("R2 all expected port events seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule